// File: doc/BRIEF.md
# BCD Clock Calendar with Alarm

This block keeps the time of day and the calendar, from seconds up to a two-digit year, and moves forward one second on each cycle in which a 1 Hz tick enable is high. Seconds, minutes, hours, days, months and years are stored as packed BCD. A binary weekday counter steps with the day. The year uses the plain divisible-by-four leap rule. A century bit flips each time the year wraps past 99.

An alarm comparator looks at minute, hour, day and weekday. Each of these fields has its own active-low enable. When the time reaches second 00 and every enabled field matches, a sticky alarm flag is set. That flag, gated by an enable bit, drives the interrupt output. Software reaches all registers through a simple port with separate read and write strobes.

While a read of a time register is in progress, the counters hold still, so a value is never torn across a carry. Ticks that arrive during that time are held back and applied afterward, one per cycle. A voltage-low input sets a flag in the seconds register. Only software can clear that flag.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, every register reads 0, with two exceptions. The seconds register reads 0x80 (voltage-low flag set). The four alarm registers (0x9 to 0xC) read 0x80 (all alarm fields disabled). The interrupt output is 0.
- R2: A read request at address A returns the register contents on reg_rdata in the cycle after the request. The map is: 0x1 control (bit 3 alarm flag, bit 1 interrupt enable), 0x2 seconds (bit 7 voltage-low), 0x3 minutes, 0x4 hours, 0x5 day, 0x6 weekday, 0x7 month (bit 7 century), 0x8 year, 0x9 alarm minute, 0xA alarm hour, 0xB alarm day, 0xC alarm weekday. The unmapped addresses 0x0, 0xD, 0xE and 0xF read 0, and writes to them are ignored.
- R3: Each step advances seconds in BCD. Seconds 59 become 00 and carry into minutes. Minutes 59 become 00 and carry into hours. Hours 23 become 00 and carry into the day.
- R4: The day wraps to 01 after the last day of its month. April, June, September and November have 30 days. February has 28 days, or 29 when the BCD year is divisible by 4. All other months have 31 days.
- R5: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00 and toggles the century bit (bit 7 of the month register).
- R6: The weekday is binary 0 to 6. It advances whenever the day advances, and it wraps from 6 to 0.
- R7: While reg_rd is high with an address in 0x2 to 0x8, no counter changes. Ticks that arrive meanwhile are counted, up to 2^PEND_W-1. They are applied one step per cycle once the freeze ends.
- R8: A tick that arrives in a cycle with reg_wr high is deferred in the same way as a tick during a freeze. The write is not corrupted, and the tick is not lost.
- R9: Bit 7 of each alarm field is an active-low enable. The alarm flag is set by a step that lands on seconds 00, provided at least one field is enabled and every enabled field equals the new time. With all fields disabled, the flag is never set.
- R10: The alarm flag stays set until a write to 0x1 with bit 3 = 0. A write with bit 3 = 1 leaves the flag unchanged.
- R11: irq_alarm is high exactly when the alarm flag and the interrupt enable (bit 1 of 0x1) are both 1.
- R12: vlow_in high sets seconds bit 7. A write to 0x2 with bit 7 = 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| vlow_in | input | 1 | Supply-low indication |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read request (held to keep the freeze) |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| irq_alarm | output | 1 | Alarm interrupt contribution |

## Verification
Read data appears one clock after the read request. The counters, the alarm flag and the voltage-low flag change at the same edge that samples the tick, the write or vlow_in. irq_alarm follows the flag with no extra delay. Deferred ticks land one per cycle after the freeze or write cycle ends. The bench therefore waits a few idle cycles before it reads back a frozen counter. Every expected read value is queued when the request is driven, and it is compared at the falling edge after the registered response.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int PEND_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       vlow_in,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  output logic       irq_alarm
);

  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [7:0] sec;
  logic [6:0] min;
  logic [5:0] hr;
  logic [5:0] day;
  logic [2:0] wday;
  logic [4:0] mon;
  logic       cent;
  logic [7:0] yr;
  logic [7:0] al_min, al_hr, al_day, al_wd;
  logic       af, aie;
  logic [PEND_W-1:0] pend;

  logic time_addr, frz, hold, step;
  assign time_addr = (reg_addr >= 4'h2) && (reg_addr <= 4'h8);
  assign frz  = reg_rd && time_addr;
  assign hold = frz || reg_wr;
  assign step = !hold && (tick_1hz || pend != '0);

  logic leap;
  logic [5:0] last_day;
  assign leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                      : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);

  always_comb begin
    case (mon)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  end

  logic w_sec, w_min, w_hr, w_day, w_mon, w_yr;
  assign w_sec = sec[6:0] == 7'h59;
  assign w_min = min == 7'h59;
  assign w_hr  = hr == 6'h23;
  assign w_day = day == last_day;
  assign w_mon = mon == 5'h12;
  assign w_yr  = yr == 8'h99;

  logic c_min, c_hr, c_day, c_mon, c_yr;
  assign c_min = w_sec;
  assign c_hr  = c_min && w_min;
  assign c_day = c_hr && w_hr;
  assign c_mon = c_day && w_day;
  assign c_yr  = c_mon && w_mon;

  logic [7:0] i_sec, i_min, i_hr, i_day, i_mon, i_yr;
  assign i_sec = bcd_inc({1'b0, sec[6:0]});
  assign i_min = bcd_inc({1'b0, min});
  assign i_hr  = bcd_inc({2'b0, hr});
  assign i_day = bcd_inc({2'b0, day});
  assign i_mon = bcd_inc({3'b0, mon});
  assign i_yr  = bcd_inc(yr);

  logic [6:0] n_sec, n_min;
  logic [5:0] n_hr, n_day;
  logic [2:0] n_wd;
  logic [4:0] n_mon;
  logic [7:0] n_yr;
  logic       n_cent;
  assign n_sec  = w_sec ? 7'h00 : i_sec[6:0];
  assign n_min  = !c_min ? min  : (w_min ? 7'h00 : i_min[6:0]);
  assign n_hr   = !c_hr  ? hr   : (w_hr  ? 6'h00 : i_hr[5:0]);
  assign n_day  = !c_day ? day  : (w_day ? 6'h01 : i_day[5:0]);
  assign n_wd   = !c_day ? wday : (wday == 3'd6 ? 3'd0 : wday + 3'd1);
  assign n_mon  = !c_mon ? mon  : (w_mon ? 5'h01 : i_mon[4:0]);
  assign n_yr   = !c_yr  ? yr   : (w_yr  ? 8'h00 : i_yr);
  assign n_cent = cent ^ (c_yr && w_yr);

  logic any_en, m_all, hit;
  assign any_en = !(al_min[7] && al_hr[7] && al_day[7] && al_wd[7]);
  assign m_all  = (al_min[7] || al_min[6:0] == n_min) &&
                  (al_hr[7]  || al_hr[5:0]  == n_hr)  &&
                  (al_day[7] || al_day[5:0] == n_day) &&
                  (al_wd[7]  || al_wd[2:0]  == n_wd);
  assign hit = step && n_sec == 7'h00 && any_en && m_all;

  logic [7:0] rd_mux;
  always_comb begin
    case (reg_addr)
      4'h1:    rd_mux = {4'b0, af, 1'b0, aie, 1'b0};
      4'h2:    rd_mux = sec;
      4'h3:    rd_mux = {1'b0, min};
      4'h4:    rd_mux = {2'b0, hr};
      4'h5:    rd_mux = {2'b0, day};
      4'h6:    rd_mux = {5'b0, wday};
      4'h7:    rd_mux = {cent, 2'b0, mon};
      4'h8:    rd_mux = yr;
      4'h9:    rd_mux = al_min;
      4'hA:    rd_mux = al_hr;
      4'hB:    rd_mux = al_day;
      4'hC:    rd_mux = al_wd;
      default: rd_mux = 8'h00;
    endcase
  end

  assign irq_alarm = af && aie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (hold && tick_1hz && pend != PEND_MAX) begin
      pend <= pend + 1'b1;
    end else if (!hold && !tick_1hz && pend != '0) begin
      pend <= pend - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= 8'h00;
    end else if (reg_rd) begin
      reg_rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec    <= 8'h80;
      min    <= '0;
      hr     <= '0;
      day    <= '0;
      wday   <= '0;
      mon    <= '0;
      cent   <= 1'b0;
      yr     <= '0;
      al_min <= 8'h80;
      al_hr  <= 8'h80;
      al_day <= 8'h80;
      al_wd  <= 8'h80;
      af     <= 1'b0;
      aie    <= 1'b0;
    end else begin
      if (step) begin
        sec[6:0] <= n_sec;
        min      <= n_min;
        hr       <= n_hr;
        day      <= n_day;
        wday     <= n_wd;
        mon      <= n_mon;
        cent     <= n_cent;
        yr       <= n_yr;
      end
      if (hit) af <= 1'b1;
      if (reg_wr) begin
        case (reg_addr)
          4'h1: begin
            aie <= reg_wdata[1];
            if (!reg_wdata[3]) af <= 1'b0;
          end
          4'h2: sec    <= reg_wdata;
          4'h3: min    <= reg_wdata[6:0];
          4'h4: hr     <= reg_wdata[5:0];
          4'h5: day    <= reg_wdata[5:0];
          4'h6: wday   <= reg_wdata[2:0];
          4'h7: begin
            cent <= reg_wdata[7];
            mon  <= reg_wdata[4:0];
          end
          4'h8: yr     <= reg_wdata;
          4'h9: al_min <= reg_wdata;
          4'hA: al_hr  <= reg_wdata;
          4'hB: al_day <= reg_wdata;
          4'hC: al_wd  <= reg_wdata;
          default: ;
        endcase
      end
      if (vlow_in) sec[7] <= 1'b1;
    end
  end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [3:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       vlow_in,
  input logic       frz,
  input logic       step,
  input logic [7:0] sec,
  input logic [6:0] min,
  input logic [5:0] hr,
  input logic [2:0] wday,
  input logic       af,
  input logic       irq_alarm
);

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !reg_wr) |=> (sec[6:0] == $past(sec[6:0]) && min == $past(min) && hr == $past(hr)));

  p_af_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (af && !(reg_wr && reg_addr == 4'h1 && !reg_wdata[3])) |=> af);

  p_af_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af) |-> $past(step));

  p_vl_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    vlow_in |=> sec[7]);

  p_sec_bcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (sec[3:0] <= 4'd9 && sec[6:4] <= 3'd5));

  p_wday_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> wday <= 3'd6);

  p_irq_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_alarm |-> af);

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .vlow_in(vlow_in), .frz(frz), .step(step),
  .sec(sec), .min(min), .hr(hr), .wday(wday), .af(af), .irq_alarm(irq_alarm)
);

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, vlow_in = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq_alarm;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_q = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rtc_calendar i_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .vlow_in(vlow_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_alarm(irq_alarm)
  );

  always @(posedge clk) rd_q <= reg_rd;

  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        failures++;
        $display("FAIL %s: rdata=%h expected=%h", t, reg_rdata, e);
      end
    end
  end

  task automatic check_bit(input logic act, input logic exp, input string t);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", t, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, w, h, m, s);
    wr(4'h2, s); wr(4'h3, m); wr(4'h4, h); wr(4'h5, d);
    wr(4'h6, w); wr(4'h7, mo); wr(4'h8, y);
  endtask

  task automatic finish_tb();
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    // R1 reset state
    check_bit(irq_alarm, 1'b0, "R1 irq");
    rd(4'h0, 8'h00, "R1 addr0");
    rd(4'h1, 8'h00, "R1 ctrl");
    rd(4'h2, 8'h80, "R1 sec");
    for (int a = 3; a <= 8; a++) rd(4'(a), 8'h00, "R1 time");
    for (int a = 9; a <= 12; a++) rd(4'(a), 8'h80, "R1 alarm");

    // R2 readback and unmapped
    wr(4'hA, 8'h12); rd(4'hA, 8'h12, "R2 alarm hour");
    wr(4'hA, 8'h80);
    wr(4'hE, 8'h55); rd(4'hE, 8'h00, "R2 unmapped");
    wr(4'h7, 8'h91); rd(4'h7, 8'h91, "R2 month+century");

    // R3 carries, R12 clear via write
    set_time(8'h23, 8'h06, 8'h15, 8'h03, 8'h23, 8'h59, 8'h58);
    rd(4'h2, 8'h58, "R12 cleared by write");
    tick(); rd(4'h2, 8'h59, "R3 sec inc");
    tick();
    rd(4'h2, 8'h00, "R3 sec wrap");
    rd(4'h3, 8'h00, "R3 min wrap");
    rd(4'h4, 8'h00, "R3 hour wrap");
    rd(4'h5, 8'h16, "R3 day carry");
    rd(4'h6, 8'h04, "R6 weekday step");

    // R4 month lengths
    set_time(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    tick(); rd(4'h5, 8'h01, "R4 feb28 nonleap"); rd(4'h7, 8'h03, "R4 to march");
    set_time(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    tick(); rd(4'h5, 8'h29, "R4 leap feb29");
    set_time(8'h24, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59);
    tick(); rd(4'h5, 8'h01, "R4 leap wrap"); rd(4'h7, 8'h03, "R4 leap march");
    set_time(8'h24, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    tick(); rd(4'h5, 8'h01, "R4 april30"); rd(4'h7, 8'h05, "R4 may");
    set_time(8'h24, 8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    tick(); rd(4'h5, 8'h31, "R4 jan31 exists");

    // R5 year wrap, R6 weekday wrap
    set_time(8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    tick();
    rd(4'h8, 8'h00, "R5 year wrap");
    rd(4'h7, 8'h81, "R5 century toggle");
    rd(4'h5, 8'h01, "R5 day");
    rd(4'h6, 8'h00, "R6 weekday wrap");

    // R7 freeze with deferred ticks
    set_time(8'h24, 8'h05, 8'h10, 8'h02, 8'h10, 8'h00, 8'h10);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'h2;
    exp_q.push_back(8'h10); tag_q.push_back("R7 frozen");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      tick_1hz = (i < 3);
      exp_q.push_back(8'h10); tag_q.push_back("R7 frozen");
    end
    @(negedge clk);
    reg_rd = 1'b0; tick_1hz = 1'b0;
    idle(5);
    rd(4'h2, 8'h13, "R7 deferred ticks applied");

    // R8 tick during write
    @(negedge clk);
    tick_1hz = 1'b1; reg_wr = 1'b1; reg_addr = 4'h9; reg_wdata = 8'h80;
    @(negedge clk);
    tick_1hz = 1'b0; reg_wr = 1'b0;
    idle(3);
    rd(4'h2, 8'h14, "R8 tick kept");
    rd(4'h9, 8'h80, "R8 write kept");

    // R9 alarm, R11 irq
    wr(4'h9, 8'h05);
    wr(4'h1, 8'h02);
    set_time(8'h24, 8'h05, 8'h10, 8'h02, 8'h10, 8'h04, 8'h58);
    tick();
    check_bit(irq_alarm, 1'b0, "R9 no alarm before match");
    tick();
    check_bit(irq_alarm, 1'b1, "R11 irq on alarm");
    rd(4'h1, 8'h0A, "R9 alarm flag set");

    // R10 sticky and clear rules
    wr(4'h1, 8'h0A);
    rd(4'h1, 8'h0A, "R10 write 1 keeps flag");
    tick();
    rd(4'h1, 8'h0A, "R10 flag stays after mismatch");
    wr(4'h1, 8'h08);
    check_bit(irq_alarm, 1'b0, "R11 enable off masks irq");
    rd(4'h1, 8'h08, "R10 flag kept, enable off");
    wr(4'h1, 8'h0A);
    check_bit(irq_alarm, 1'b1, "R11 enable on");
    wr(4'h1, 8'h02);
    rd(4'h1, 8'h02, "R10 flag cleared");
    check_bit(irq_alarm, 1'b0, "R11 irq cleared");

    // R9 all fields disabled
    wr(4'h9, 8'h80);
    wr(4'h2, 8'h59);
    tick();
    rd(4'h1, 8'h02, "R9 disabled alarm never fires");

    // R12 voltage-low
    @(negedge clk); vlow_in = 1'b1;
    @(negedge clk); vlow_in = 1'b0;
    rd(4'h2, 8'h80, "R12 vl set");
    wr(4'h2, 8'h30);
    rd(4'h2, 8'h30, "R12 vl cleared");

    finish_tb();
  end
endmodule